// File: doc/BRIEF.md
# Switch Closure Duty and Event Accumulator

This block observes a bank of debounced switch-closure inputs on a periodic sampling tick, nominally once every 2 ms, supplied as an enable from a clock divider elsewhere. On every tick each channel keeps three running totals:
- the number of ticks in which the switch was closed (duty total);
- the number of ticks seen in its current window (sample total), so that duty cycle is duty over samples;
- the number of open-to-closed transitions (event count).

A host reads one channel at a time by raising a request strobe with a channel index. One cycle later the block returns that channel's latest sampled state and its three totals, with a single-cycle valid pulse. In the same step it clears that channel's totals, and every other channel keeps accumulating. No host read is needed to start sampling, so the first read after reset covers the whole time since reset. When totals go unread they wrap to zero instead of saturating. The event count wraps on its own, after about 655 s at a 100 Hz input. The sample window wraps after 2^WIN_W ticks, about 131 s at the default width, and that wrap also discards the duty total.

Top module: `swc_accum`

## Requirements
- R1: After reset, every channel's totals are zero, its stored state is open (0), and rd_valid_o is low. A read before any tick returns all zeros.
- R2: A rd_req_i sampled at a clock edge causes rd_valid_o to be high for exactly the following cycle, with the data fields of channel rd_ch_i. Without a request, rd_valid_o is low.
- R3: On each tick, a channel's sample total increases by one. Its duty total increases by one when sw_i for that channel is 1 (closed) at the tick.
- R4: A channel's event count increases by one at a tick where sw_i is 1 and the state stored at the previous tick is 0. The stored state starts at 0, so a switch already closed at the first tick counts as one event.
- R5: Input changes in cycles without tick_i have no effect on any total or on the stored state.
- R6: A read clears the duty, sample and event totals of the selected channel to zero. The stored state is kept.
- R7: A read leaves every unselected channel's totals and state untouched.
- R8: When tick_i and rd_req_i coincide, the returned values include that tick's sample, and the selected channel's totals are zero afterwards.
- R9: The event count wraps from 2^CNT_W-1 to 0 with no saturation.
- R10: A tick that would take the sample total past 2^WIN_W-1 sets both the sample total and the duty total to zero.
- R11: rd_state_o returns the channel's most recently sampled switch level. When a tick coincides with the read, this is the level at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling enable, one cycle per sample period |
| sw_i | input | NUM_CH | Debounced switch levels, 1 = closed |
| rd_req_i | input | 1 | Read-and-clear request strobe |
| rd_ch_i | input | CH_W | Channel index of the read |
| rd_valid_o | output | 1 | One-cycle pulse marking returned data |
| rd_state_o | output | 1 | Latest sampled level of the read channel |
| rd_duty_o | output | WIN_W | Closed-sample total |
| rd_samples_o | output | WIN_W | Elapsed-sample total |
| rd_count_o | output | CNT_W | Open-to-closed event total |

## Verification
The bench builds the block with eight channels, a 3-bit event count and a 4-bit sample window. With these widths the event count wraps after eight closures and the window wraps after sixteen ticks, so R9 and R10 are reached within a few dozen cycles instead of tens of thousands of ticks. The bench carries its own model of every channel's totals, so side effects on unselected channels show up in later reads. A coinciding tick and read is driven on purpose to fix the ordering given in R8.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_WIN_W  = 16;
  localparam int unsigned DEF_CNT_W  = 16;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/swc_chan.sv
module swc_chan #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sw_i,
  input  logic             clr_i,
  output logic             view_state_o,
  output logic [WIN_W-1:0] view_duty_o,
  output logic [WIN_W-1:0] view_samples_o,
  output logic [CNT_W-1:0] view_count_o
);
  logic             st_q, st_n;
  logic [WIN_W-1:0] duty_q, duty_n, samp_q, samp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise, win_full;

  assign rise     = sw_i & ~st_q;
  assign win_full = &samp_q;

  always_comb begin
    st_n   = st_q;
    duty_n = duty_q;
    samp_n = samp_q;
    cnt_n  = cnt_q;
    if (tick_i) begin
      st_n  = sw_i;
      cnt_n = cnt_q + CNT_W'(rise);
      if (win_full) begin
        // window expired: restart duty data with it
        samp_n = '0;
        duty_n = '0;
      end else begin
        samp_n = samp_q + WIN_W'(1);
        duty_n = duty_q + WIN_W'(sw_i);
      end
    end
  end

  // read view includes a same-cycle tick
  assign view_state_o   = st_n;
  assign view_duty_o    = duty_n;
  assign view_samples_o = samp_n;
  assign view_count_o   = cnt_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= 1'b0;
      duty_q <= '0;
      samp_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_n;
      if (clr_i) begin
        duty_q <= '0;
        samp_q <= '0;
        cnt_q  <= '0;
      end else begin
        duty_q <= duty_n;
        samp_q <= samp_n;
        cnt_q  <= cnt_n;
      end
    end
  end

  assert_duty_le_samples_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= samp_q);

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> ($stable(duty_q) && $stable(samp_q) && $stable(cnt_q) && $stable(st_q)));

  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (duty_q == '0 && samp_q == '0 && cnt_q == '0));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  assert_window_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && win_full) |=> (samp_q == '0 && duty_q == '0));
endmodule

// File: rtl/swc_rd_mux.sv
module swc_rd_mux #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_req_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  input  logic             state_i   [NUM_CH],
  input  logic [WIN_W-1:0] duty_i    [NUM_CH],
  input  logic [WIN_W-1:0] samples_i [NUM_CH],
  input  logic [CNT_W-1:0] count_i   [NUM_CH],
  output logic             rd_valid_o,
  output logic             rd_state_o,
  output logic [WIN_W-1:0] rd_duty_o,
  output logic [WIN_W-1:0] rd_samples_o,
  output logic [CNT_W-1:0] rd_count_o
);
  logic             sel_state;
  logic [WIN_W-1:0] sel_duty, sel_samp;
  logic [CNT_W-1:0] sel_cnt;

  always_comb begin
    sel_state = 1'b0;
    sel_duty  = '0;
    sel_samp  = '0;
    sel_cnt   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch_i == CH_W'(i)) begin
        sel_state = state_i[i];
        sel_duty  = duty_i[i];
        sel_samp  = samples_i[i];
        sel_cnt   = count_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_state_o   <= 1'b0;
      rd_duty_o    <= '0;
      rd_samples_o <= '0;
      rd_count_o   <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) begin
        rd_state_o   <= sel_state;
        rd_duty_o    <= sel_duty;
        rd_samples_o <= sel_samp;
        rd_count_o   <= sel_cnt;
      end
    end
  end

  assert_valid_from_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i));

  assert_ret_duty_le_samples_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_duty_o <= rd_samples_o));
endmodule

// File: rtl/swc_accum.sv
module swc_accum
  import swc_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned WIN_W  = DEF_WIN_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned CH_W  = idx_bits(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NUM_CH-1:0] sw_i,
  input  logic              rd_req_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic              rd_valid_o,
  output logic              rd_state_o,
  output logic [WIN_W-1:0]  rd_duty_o,
  output logic [WIN_W-1:0]  rd_samples_o,
  output logic [CNT_W-1:0]  rd_count_o
);
  logic             v_state [NUM_CH];
  logic [WIN_W-1:0] v_duty  [NUM_CH];
  logic [WIN_W-1:0] v_samp  [NUM_CH];
  logic [CNT_W-1:0] v_cnt   [NUM_CH];
  logic [NUM_CH-1:0] clr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign clr[g] = rd_req_i && (rd_ch_i == CH_W'(g));

    swc_chan #(
      .WIN_W(WIN_W),
      .CNT_W(CNT_W)
    ) u_chan (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick_i),
      .sw_i          (sw_i[g]),
      .clr_i         (clr[g]),
      .view_state_o  (v_state[g]),
      .view_duty_o   (v_duty[g]),
      .view_samples_o(v_samp[g]),
      .view_count_o  (v_cnt[g])
    );
  end

  swc_rd_mux #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .WIN_W (WIN_W),
    .CNT_W (CNT_W)
  ) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req_i),
    .rd_ch_i     (rd_ch_i),
    .state_i     (v_state),
    .duty_i      (v_duty),
    .samples_i   (v_samp),
    .count_i     (v_cnt),
    .rd_valid_o  (rd_valid_o),
    .rd_state_o  (rd_state_o),
    .rd_duty_o   (rd_duty_o),
    .rd_samples_o(rd_samples_o),
    .rd_count_o  (rd_count_o)
  );

  assert_one_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));

  assert_no_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);
endmodule

// File: tb/sim_swc_accum.sv
`timescale 1ns/1ps
module sim_swc_accum;
  localparam int NCH  = 8;
  localparam int WW   = 4;
  localparam int CW   = 3;
  localparam int WMOD = 1 << WW;
  localparam int CMOD = 1 << CW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [NCH-1:0] sw = '0;
  logic           req = 1'b0;
  logic [2:0]     ch = '0;
  logic           vld, st;
  logic [WW-1:0]  duty, samp;
  logic [CW-1:0]  cnt;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st[NCH], m_duty[NCH], m_samp[NCH], m_cnt[NCH];

  always #2.5 clk = ~clk;

  swc_accum #(.NUM_CH(NCH), .WIN_W(WW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sw_i(sw),
    .rd_req_i(req), .rd_ch_i(ch), .rd_valid_o(vld), .rd_state_o(st),
    .rd_duty_o(duty), .rd_samples_o(samp), .rd_count_o(cnt));

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_tick(logic [NCH-1:0] s);
    for (int c = 0; c < NCH; c++) begin
      if (s[c] && m_st[c] == 0) m_cnt[c] = (m_cnt[c] + 1) % CMOD;
      m_st[c] = s[c];
      if (m_samp[c] == WMOD - 1) begin
        m_samp[c] = 0;
        m_duty[c] = 0;
      end else begin
        m_samp[c]++;
        m_duty[c] += s[c];
      end
    end
  endtask

  // one cycle from a negedge to the next; optional tick and read with check
  task automatic step(bit t, logic [NCH-1:0] s, bit r, int c, string tag);
    int e_st, e_duty, e_samp, e_cnt;
    tick = t; sw = s; req = r; ch = 3'(c);
    if (t) model_tick(s);
    e_st = m_st[c]; e_duty = m_duty[c]; e_samp = m_samp[c]; e_cnt = m_cnt[c];
    if (r) begin
      m_duty[c] = 0; m_samp[c] = 0; m_cnt[c] = 0;
    end
    @(negedge clk);
    tick = 1'b0; req = 1'b0;
    if (r) begin
      check(tag, "valid", int'(vld), 1);
      check(tag, "state", int'(st), e_st);
      check(tag, "duty", int'(duty), e_duty);
      check(tag, "samples", int'(samp), e_samp);
      check(tag, "count", int'(cnt), e_cnt);
    end
  endtask

  task automatic t_reset;
    check("R1", "valid", int'(vld), 0);
    check("R1", "duty", int'(duty), 0);
    check("R1", "count", int'(cnt), 0);
    step(0, '0, 1, 3, "R1");
  endtask

  task automatic t_valid;
    step(0, '0, 0, 0, "R2");
    check("R2", "valid idle", int'(vld), 0);
    step(0, '0, 1, 5, "R2");
    step(0, '0, 0, 0, "R2");
    check("R2", "valid drop", int'(vld), 0);
  endtask

  task automatic t_duty;
    logic [8:0] pat = 9'b101100101;
    for (int i = 0; i < 9; i++) step(1, {7'b0, pat[i]}, 0, 0, "R3");
    step(0, {7'b0, pat[8]}, 1, 0, "R3");
  endtask

  task automatic t_count;
    logic [5:0] pat = 6'b101101;
    step(0, '0, 1, 1, "R4");
    for (int i = 0; i < 6; i++) step(1, {6'b0, pat[i], 1'b0}, 0, 0, "R4");
    step(0, '0, 1, 1, "R4");
  endtask

  task automatic t_idle;
    step(0, '0, 1, 2, "R5");
    step(1, 8'h04, 0, 0, "R5");
    for (int i = 0; i < 6; i++) step(0, (i % 2) ? 8'hFF : 8'h00, 0, 0, "R5");
    step(0, 8'h00, 1, 2, "R5");
  endtask

  task automatic t_clear;
    step(1, 8'h01, 0, 0, "R6");
    step(0, 8'h01, 1, 0, "R6");
    step(0, 8'h00, 1, 0, "R6");
    check("R11", "state kept", int'(st), 1);
  endtask

  task automatic t_iso;
    step(0, '0, 1, 5, "R7");
    for (int i = 0; i < 3; i++) step(1, 8'hFF, 0, 0, "R7");
    step(0, 8'hFF, 1, 4, "R7");
    step(0, 8'hFF, 1, 5, "R7");
  endtask

  task automatic t_same;
    step(0, 8'h00, 1, 6, "R8");
    step(1, 8'h40, 0, 0, "R8");
    step(1, 8'h00, 1, 6, "R8");
    check("R11", "tick level", int'(st), 0);
    step(0, 8'h00, 1, 6, "R8");
  endtask

  task automatic t_cwrap;
    step(0, 8'h00, 1, 7, "R9");
    for (int i = 0; i < CMOD; i++) begin
      step(1, 8'h80, 0, 0, "R9");
      step(1, 8'h00, 0, 0, "R9");
    end
    step(0, 8'h00, 1, 7, "R9");
    check("R9", "wrapped count", int'(cnt), 0);
    for (int i = 0; i <= CMOD; i++) begin
      step(1, 8'h80, 0, 0, "R9");
      step(1, 8'h00, 0, 0, "R9");
    end
    step(0, 8'h00, 1, 7, "R9");
    check("R9", "wrap plus one", int'(cnt), 1);
  endtask

  task automatic t_wwrap;
    step(0, 8'h08, 1, 3, "R10");
    for (int i = 0; i < WMOD; i++) step(1, 8'h08, 0, 0, "R10");
    step(0, 8'h08, 1, 3, "R10");
    check("R10", "samples at wrap", int'(samp), 0);
    for (int i = 0; i <= WMOD; i++) step(1, 8'h08, 0, 0, "R10");
    step(0, 8'h08, 1, 3, "R10");
    check("R10", "duty after wrap", int'(duty), 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_st[c] = 0; m_duty[c] = 0; m_samp[c] = 0; m_cnt[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid();
    t_duty();
    t_count();
    t_idle();
    t_clear();
    t_iso();
    t_same();
    t_cwrap();
    t_wwrap();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule